// File: doc/BRIEF.md
# Paired Round-Robin Lane Distributor

This block spreads one serial bit stream over a group of parallel encoder lanes and gathers the lanes' serial outputs back into a single stream. Together the two halves give a 1:8 interleave. Bits are dealt out in pairs: two consecutive accepted bits go to one lane, then the next lane takes the following two, and so on round-robin. After sixteen bits the order starts again at lane 0.

On the ingress side the input bit is driven to every lane at once. Only the selected lane receives a capture enable. On the egress side a second, independent step counter picks the lane whose output bit is forwarded. The same counter raises that lane's shift enable so the lane moves its next bit forward. No clock is gated anywhere; every lane runs on the common clock and acts only on its own enable.

Each side's step counter is a synchronous binary counter. Its upper bits give the lane index and its lower bits give the position within the pair. A build option lets the counter update on the falling clock edge, half a cycle away from the rising edge where lanes capture data. Either way, the selection seen at each capture edge is the one set up by the earlier accepted bits.

Top module: `lane_pair_distributor`

## Requirements
- R1: After reset is released, no capture enable and no shift enable is active while their strobes are low, and both the first and second accepted input bits go to lane 0, and the first two delivered output bits come from lane 0.
- R2: `lane_din` equals `in_bit` on every cycle, so every lane sees the same input bit.
- R3: On a cycle with `in_valid` high, exactly one bit of `lane_cap_en` is set, bit k, where k = floor(n / 2) mod 8 and n is the number of input bits accepted since reset.
- R4: Accepted input bits number 2j and 2j+1 go to the same lane, and bit 2j+2 goes to the next higher lane index. The lane index is bits [3:1] of a 4-bit count of accepted bits.
- R5: A cycle with `in_valid` low sets no bit of `lane_cap_en` and does not move the input selection.
- R6: After sixteen accepted input bits, the input selection wraps from lane 7 back to lane 0. The output selection does the same after sixteen delivered bits.
- R7: On a cycle with `out_req` high, exactly one bit of `lane_shift_en` is set, bit k with k = floor(m / 2) mod 8, where m is the number of output bits delivered since reset. In the same cycle `out_bit` equals `lane_dout[k]`.
- R8: A cycle with `out_req` low sets no bit of `lane_shift_en` and does not move the output selection. The output selection advances independently of input traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock; lanes capture and shift on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input bit is offered and accepted this cycle |
| in_bit | input | 1 | Serial input data bit |
| lane_din | output | 1 | Input bit broadcast to all lanes |
| lane_cap_en | output | 8 | One-hot capture enable, bit k for lane k |
| out_req | input | 1 | Downstream takes an output bit this cycle |
| lane_dout | input | 8 | Current serial output bit of each lane, bit k from lane k |
| lane_shift_en | output | 8 | One-hot shift enable, bit k for lane k |
| out_bit | output | 1 | Merged serial output bit |

## Verification
The bound checker watches four things on every clock edge. It checks that the capture and shift enables are one-hot exactly when their strobes are high. It checks that the forwarded bit comes from the lane being shifted. Using its own position counters, it checks that each pair stays on one lane and that the lane then moves on by one, wrapping from 7 to 0. The exact lane numbers in the order, and the rule that the first pair after reset lands on lane 0, depend on the absolute count since reset. The bench scoreboard shows these across gapped and back-to-back traffic. Only the bench scenarios can show that idle cycles leave each selection where it was, and that input and output traffic do not disturb each other.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
   // Which clock edge moves the lane selection forward.
   typedef enum logic {
      STEP_SAME_EDGE     = 1'b0,
      STEP_OPPOSITE_EDGE = 1'b1
   } step_edge_e;
endpackage

// File: rtl/lpd_step_counter.sv
module lpd_step_counter
   import lpd_pkg::*;
#(
   parameter int         CNT_W     = 4,
   parameter step_edge_e STEP_EDGE = STEP_OPPOSITE_EDGE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 1) begin : g_bad_width
      $error("lpd_step_counter: CNT_W must be at least 1");
   end

   if (STEP_EDGE == STEP_OPPOSITE_EDGE) begin : g_neg
      // Advance request is captured on the rising edge together with the
      // lane data, then applied on the falling edge, so the selection never
      // changes near a capture edge.
      logic adv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) adv_q <= 1'b0;
         else        adv_q <= adv;
      end
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n)     count <= '0;
         else if (adv_q) count <= count + 1'b1;
      end
   end else begin : g_pos
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   count <= '0;
         else if (adv) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/lpd_lane_decode.sv
module lpd_lane_decode #(
   parameter int LANES   = 8,
   parameter int SEL_W   = 3,
   parameter int GROUP_W = 1,
   localparam int CNT_W  = SEL_W + GROUP_W
) (
   input  logic [CNT_W-1:0] count,
   output logic [LANES-1:0] onehot
);
   logic [SEL_W-1:0] lane_idx;
   assign lane_idx = count[CNT_W-1:GROUP_W];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign onehot[i] = (lane_idx == SEL_W'(i));
   end
endmodule

// File: rtl/lane_pair_distributor.sv
module lane_pair_distributor
   import lpd_pkg::*;
#(
   parameter int         LANES     = 8,
   parameter int         GROUP     = 2,
   parameter step_edge_e STEP_EDGE = STEP_OPPOSITE_EDGE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_bit,
   output logic             lane_din,
   output logic [LANES-1:0] lane_cap_en,
   input  logic             out_req,
   input  logic [LANES-1:0] lane_dout,
   output logic [LANES-1:0] lane_shift_en,
   output logic             out_bit
);
   localparam int SEL_W   = $clog2(LANES);
   localparam int GROUP_W = $clog2(GROUP);
   localparam int CNT_W   = SEL_W + GROUP_W;

   if (LANES < 2 || (1 << SEL_W) != LANES) begin : g_bad_lanes
      $error("lane_pair_distributor: LANES must be a power of two >= 2");
   end
   if (GROUP < 1 || (1 << GROUP_W) != GROUP) begin : g_bad_group
      $error("lane_pair_distributor: GROUP must be a power of two >= 1");
   end

   logic [CNT_W-1:0] in_cnt;
   logic [CNT_W-1:0] out_cnt;
   logic [LANES-1:0] in_sel;
   logic [LANES-1:0] out_sel;

   // Ingress: one counter, one decoder, broadcast data.
   lpd_step_counter #(.CNT_W(CNT_W), .STEP_EDGE(STEP_EDGE)) u_in_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (in_valid),
      .count (in_cnt)
   );

   lpd_lane_decode #(.LANES(LANES), .SEL_W(SEL_W), .GROUP_W(GROUP_W)) u_in_dec (
      .count  (in_cnt),
      .onehot (in_sel)
   );

   assign lane_din    = in_bit;
   assign lane_cap_en = in_sel & {LANES{in_valid}};

   // Egress: its own counter, so output order is independent of input.
   lpd_step_counter #(.CNT_W(CNT_W), .STEP_EDGE(STEP_EDGE)) u_out_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (out_req),
      .count (out_cnt)
   );

   lpd_lane_decode #(.LANES(LANES), .SEL_W(SEL_W), .GROUP_W(GROUP_W)) u_out_dec (
      .count  (out_cnt),
      .onehot (out_sel)
   );

   assign lane_shift_en = out_sel & {LANES{out_req}};
   assign out_bit       = |(lane_dout & out_sel);
endmodule

// File: rtl/lpd_checker.sv
module lpd_checker #(
   parameter int LANES = 8,
   parameter int GROUP = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [LANES-1:0] lane_cap_en,
   input logic             out_req,
   input logic [LANES-1:0] lane_dout,
   input logic [LANES-1:0] lane_shift_en,
   input logic             out_bit
);
   localparam int POS_W = (GROUP > 1) ? $clog2(GROUP) : 1;

   logic             cap_seen, sh_seen;
   logic [POS_W-1:0] cap_pos, sh_pos;
   logic [LANES-1:0] cap_last, sh_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_seen <= 1'b0;
         cap_pos  <= '0;
         cap_last <= '0;
         sh_seen  <= 1'b0;
         sh_pos   <= '0;
         sh_last  <= '0;
      end else begin
         if (in_valid) begin
            cap_seen <= 1'b1;
            cap_last <= lane_cap_en;
            cap_pos  <= (int'(cap_pos) == GROUP - 1) ? '0 : cap_pos + 1'b1;
         end
         if (out_req) begin
            sh_seen <= 1'b1;
            sh_last <= lane_shift_en;
            sh_pos  <= (int'(sh_pos) == GROUP - 1) ? '0 : sh_pos + 1'b1;
         end
      end
   end

   AST_CAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_cap_en) && ((|lane_cap_en) == in_valid)); // R3
   AST_CAP_FIRST_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cap_seen) |-> lane_cap_en[0]); // R1
   AST_CAP_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cap_seen && cap_pos != '0) |-> (lane_cap_en == cap_last)); // R4
   AST_CAP_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cap_seen && cap_pos == '0) |->
         (lane_cap_en == {cap_last[LANES-2:0], cap_last[LANES-1]})); // R6
   AST_SHIFT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_shift_en) && ((|lane_shift_en) == out_req)); // R7
   AST_OUT_FROM_SHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
      out_req |-> (out_bit == |(lane_dout & lane_shift_en))); // R7
   AST_SHIFT_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req && sh_seen && sh_pos != '0) |-> (lane_shift_en == sh_last)); // R8
   AST_SHIFT_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req && sh_seen && sh_pos == '0) |->
         (lane_shift_en == {sh_last[LANES-2:0], sh_last[LANES-1]})); // R6
endmodule

bind lane_pair_distributor lpd_checker #(.LANES(LANES), .GROUP(GROUP)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .lane_cap_en   (lane_cap_en),
   .out_req       (out_req),
   .lane_dout     (lane_dout),
   .lane_shift_en (lane_shift_en),
   .out_bit       (out_bit)
);

// File: tb/lane_pair_distributor_tb.sv
module lane_pair_distributor_tb;
   localparam int LANES = 8;
   localparam int GROUP = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_bit = 1'b0;
   logic             lane_din;
   logic [LANES-1:0] lane_cap_en;
   logic             out_req = 1'b0;
   logic [LANES-1:0] lane_dout = '0;
   logic [LANES-1:0] lane_shift_en;
   logic             out_bit;

   int n_checks = 0;
   int n_fail   = 0;
   int n_in     = 0;
   int n_out    = 0;
   int q_in[$];
   int q_out[$];
   logic [15:0] lfsr = 16'hACE1;
   bit done = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   lane_pair_distributor #(.LANES(LANES), .GROUP(GROUP)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_bit        (in_bit),
      .lane_din      (lane_din),
      .lane_cap_en   (lane_cap_en),
      .out_req       (out_req),
      .lane_dout     (lane_dout),
      .lane_shift_en (lane_shift_en),
      .out_bit       (out_bit)
   );

   function automatic string tag_for(int idx);
      if (idx < GROUP)            return "R1";
      if (idx >= LANES * GROUP)   return "R6";
      return "R4";
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic next_rand();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   // Driver: applies one cycle of stimulus and records expected items.
   task automatic step(bit v, bit r);
      next_rand();
      in_valid  = v;
      in_bit    = lfsr[0];
      out_req   = r;
      lane_dout = lfsr[LANES:1];
      if (v) begin q_in.push_back(n_in);  n_in++;  end
      if (r) begin q_out.push_back(n_out); n_out++; end
      @(posedge clk);
      #1;
   endtask

   // Monitor: samples 1 ns before each rising edge.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && !done) begin
            check(lane_din == in_bit, "R2", "broadcast bit", lane_din, in_bit);
            if (in_valid) begin
               int idx, lane;
               idx  = q_in.pop_front();
               lane = (idx / GROUP) % LANES;
               check(lane_cap_en == LANES'(1 << lane), tag_for(idx),
                     "capture enable", lane_cap_en, 1 << lane);
               check(lane_cap_en == LANES'(1 << lane), "R3",
                     "capture lane", lane_cap_en, 1 << lane);
            end else begin
               check(lane_cap_en == '0, "R5", "idle capture", lane_cap_en, 0);
            end
            if (out_req) begin
               int idx, lane;
               idx  = q_out.pop_front();
               lane = (idx / GROUP) % LANES;
               check(lane_shift_en == LANES'(1 << lane), "R7",
                     "shift enable", lane_shift_en, 1 << lane);
               check(out_bit == lane_dout[lane], idx >= LANES * GROUP ? "R6" : "R7",
                     "merged bit", out_bit, lane_dout[lane]);
            end else begin
               check(lane_shift_en == '0, "R8", "idle shift", lane_shift_en, 0);
            end
         end
      end
   end

   initial begin
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1: idle after reset
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      // Back-to-back input, no output: covers pairs and wrap (R4, R6)
      for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
      // Output only, back-to-back: input selection must hold (R8, R6)
      for (int i = 0; i < 36; i++) step(1'b0, 1'b1);
      // Gapped input and output, independent patterns (R5, R8)
      for (int i = 0; i < 300; i++) begin
         next_rand();
         step(lfsr[2], lfsr[5] ^ lfsr[9]);
      end
      // Both sides full rate
      for (int i = 0; i < 64; i++) step(1'b1, 1'b1);
      step(1'b0, 1'b0);
      done = 1'b1;
      check(q_in.size() == 0, "R3", "input items left", q_in.size(), 0);
      check(q_out.size() == 0, "R7", "output items left", q_out.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule